// File: doc/BRIEF.md
# Port-Mapped Banked RAM Disk Controller

This block is the small-processor side of a banked solid-state RAM disk. It listens on an 8-bit I/O bus and answers to two consecutive port numbers. The pair starts at a base given on an input. The upper port of the pair takes the byte address, one byte per write. Each write shifts the address register left by one byte, and the register keeps only its 22 least significant bits. The lower port carries the data. Each read or write of it touches one byte of storage and then moves the address on by one.

The top three address bits pick one of eight storage units. The remaining 19 bits pick a byte inside that unit, so each unit holds 512 KiB. The storage arrays sit outside the block, behind a synchronous request interface that returns read data one cycle after the request. Each unit has its own present flag and its own write-protect flag. A read from an absent unit returns all ones. A write to an absent or protected unit is dropped. The address moves on after every data access, whether the access reached storage or not. Because of this, one stream of reads or writes can run through all eight units in turn.

Top module: `ramdisk_port_ctrl`

## Requirements
- R1: During and after reset the address is zero (st_unit = 0, st_off = 0), io_ready is 1, io_rdata is 0xFF and st_req is 0.
- R2: A strobe whose io_port equals cfg_base selects the data port. One equal to cfg_base+1 (modulo 256) selects the address port. A strobe to any other port number leaves the address unchanged and raises no st_req.
- R3: A write of byte B to the address port makes the new address equal to the old address shifted left 8 bits, masked to 22 bits, with B in bits 7:0. The new address shows on st_unit/st_off from the cycle after the strobe.
- R4: st_unit always shows address bits 21:19 and st_off always shows address bits 18:0.
- R5: A data-port read of a present unit raises st_req with st_we = 0 in the strobe cycle. io_ready is 0 in the next cycle. In the cycle after that, io_ready is 1 and io_rdata holds the byte that storage returned.
- R6: A data-port read of an absent unit raises no st_req. io_ready is 0 for one cycle, then io_rdata is 0xFF.
- R7: A data-port write to a present, unprotected unit raises st_req with st_we = 1 and st_wdata = io_wdata in the strobe cycle. io_ready stays 1.
- R8: A data-port write to an absent or write-protected unit raises no st_req, and the stored byte does not change.
- R9: Every accepted data-port read or write adds one to the 22-bit address, modulo 2^22. This carries across unit boundaries and happens even when the access was dropped.
- R10: A read of the address port leaves the address unchanged, raises no st_req and keeps io_ready at 1.
- R11: A strobe that arrives while io_ready is 0 is ignored. The address does not change and no st_req is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 8 | Port number of the data port; the address port is the next number |
| io_port | input | 8 | Port number of the current bus cycle |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wr | input | 1 | Single-cycle write strobe |
| io_wdata | input | 8 | Write data from the processor |
| io_rdata | output | 8 | Read data to the processor, valid while io_ready is 1 after a data read |
| io_ready | output | 1 | Low while a data read waits for its byte |
| unit_present | input | 8 | One present flag per unit |
| unit_wprot | input | 8 | One write-protect flag per unit |
| st_req | output | 1 | Storage request, one per reaching data access |
| st_we | output | 1 | Request is a write |
| st_unit | output | 3 | Current unit number (address bits 21:19) |
| st_off | output | 19 | Current byte offset (address bits 18:0) |
| st_wdata | output | 8 | Byte to store |
| st_rdata | input | 8 | Read byte from storage, one cycle after the request |

## Verification
st_req, st_we and st_wdata follow the strobe within the same cycle, so the bench drives each strobe at the falling edge and samples them one nanosecond later. A new address from a shift or an increment shows on st_unit/st_off after the next rising edge, and the bench reads it at the following falling edge. For a data read, io_ready is checked low at the first falling edge after the strobe edge. io_rdata and io_ready high are checked one full cycle later, which counts the storage register and the capture register. The expected address in the bench is a separate 22-bit model updated by the rules in the requirements. Read data is checked against what the bench's storage model returned or had stored.

// File: rtl/ramdisk_pkg.sv
package ramdisk_pkg;

  // Default geometry of the port-mapped RAM disk.
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_PORT_W    = 8;
  localparam int unsigned DEF_ADDR_W    = 22;
  localparam int unsigned DEF_UNIT_BITS = 3;

  // Kind of bus cycle after port decode.
  typedef enum logic [2:0] {
    CYC_NONE     = 3'd0,
    CYC_DATA_RD  = 3'd1,
    CYC_DATA_WR  = 3'd2,
    CYC_ADDR_RD  = 3'd3,
    CYC_ADDR_WR  = 3'd4
  } cyc_kind_e;

  // State of the read-return path.
  typedef enum logic {
    RR_IDLE = 1'b0,
    RR_WAIT = 1'b1
  } rr_state_e;

endpackage

// File: rtl/rdk_port_decode.sv
module rdk_port_decode #(
  parameter int unsigned PORT_W = 8
) (
  input  logic [PORT_W-1:0] cfg_base,
  input  logic [PORT_W-1:0] io_port,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              accept,
  output ramdisk_pkg::cyc_kind_e cyc_kind
);
  import ramdisk_pkg::*;

  logic [PORT_W-1:0] addr_port;
  logic              hit_data;
  logic              hit_addr;
  logic              rd_only;
  logic              wr_only;

  // Address port sits one above the data port, wrapping in the port space.
  function automatic logic [PORT_W-1:0] next_port(input logic [PORT_W-1:0] p);
    return p + {{(PORT_W-1){1'b0}}, 1'b1};
  endfunction

  assign addr_port = next_port(cfg_base);
  assign hit_data  = (io_port == cfg_base);
  assign hit_addr  = (io_port == addr_port);
  assign rd_only   = io_rd & ~io_wr;
  assign wr_only   = io_wr & ~io_rd;

  always_comb begin
    cyc_kind = CYC_NONE;
    if (accept) begin
      if (hit_data && rd_only)      cyc_kind = CYC_DATA_RD;
      else if (hit_data && wr_only) cyc_kind = CYC_DATA_WR;
      else if (hit_addr && rd_only) cyc_kind = CYC_ADDR_RD;
      else if (hit_addr && wr_only) cyc_kind = CYC_ADDR_WR;
    end
  end

endmodule

// File: rtl/rdk_addr_reg.sv
module rdk_addr_reg #(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned UNIT_BITS = 3,
  localparam int unsigned OFF_W    = ADDR_W - UNIT_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_W-1:0]    load_byte,
  input  logic                 step,
  output logic [ADDR_W-1:0]    addr_q,
  output logic [UNIT_BITS-1:0] unit,
  output logic [OFF_W-1:0]     off
);

  // Shift one byte in at the bottom; the top byte falls off the register.
  function automatic logic [ADDR_W-1:0] shift_in(input logic [ADDR_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return {a[ADDR_W-DATA_W-1:0], b};
  endfunction

  // Post-increment, wrapping in the full address space.
  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load)      addr_d = shift_in(addr_q, load_byte);
    else if (step) addr_d = bump(addr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign unit = addr_q[ADDR_W-1 -: UNIT_BITS];
  assign off  = addr_q[OFF_W-1:0];

endmodule

// File: rtl/rdk_access_gate.sv
module rdk_access_gate #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned UNIT_BITS = 3,
  localparam int unsigned N_UNITS  = 1 << UNIT_BITS
) (
  input  logic [UNIT_BITS-1:0] unit,
  input  logic [N_UNITS-1:0]   unit_present,
  input  logic [N_UNITS-1:0]   unit_wprot,
  input  logic                 data_rd,
  input  logic                 data_wr,
  input  logic [DATA_W-1:0]    wdata,
  output logic                 st_req,
  output logic                 st_we,
  output logic [DATA_W-1:0]    st_wdata,
  output logic                 rd_absent,
  output logic                 wr_dropped
);

  logic [N_UNITS-1:0] sel;
  logic               here;
  logic               locked;

  // One-hot unit select, so the present and protect flags are picked by AND-OR.
  for (genvar g = 0; g < N_UNITS; g++) begin : g_sel
    assign sel[g] = (unit == UNIT_BITS'(g));
  end

  assign here   = |(sel & unit_present);
  assign locked = |(sel & unit_wprot);

  assign st_req     = (data_rd & here) | (data_wr & here & ~locked);
  assign st_we      = data_wr & here & ~locked;
  assign st_wdata   = wdata;
  assign rd_absent  = data_rd & ~here;
  assign wr_dropped = data_wr & ~(here & ~locked);

endmodule

// File: rtl/rdk_read_return.sv
module rdk_read_return #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic              rd_absent,
  input  logic [DATA_W-1:0] st_rdata,
  output logic              io_ready,
  output logic [DATA_W-1:0] io_rdata
);
  import ramdisk_pkg::*;

  localparam logic [DATA_W-1:0] FLOAT_HIGH = '1;

  rr_state_e state_q;
  logic      absent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= RR_IDLE;
      absent_q <= 1'b0;
      io_rdata <= FLOAT_HIGH;
    end else begin
      case (state_q)
        RR_IDLE: if (rd_start) begin
          state_q  <= RR_WAIT;
          absent_q <= rd_absent;
        end
        RR_WAIT: begin
          state_q  <= RR_IDLE;
          io_rdata <= absent_q ? FLOAT_HIGH : st_rdata;
        end
        default: state_q <= RR_IDLE;
      endcase
    end
  end

  assign io_ready = (state_q == RR_IDLE);

endmodule

// File: rtl/ramdisk_port_ctrl.sv
module ramdisk_port_ctrl #(
  parameter int unsigned DATA_W    = ramdisk_pkg::DEF_DATA_W,
  parameter int unsigned PORT_W    = ramdisk_pkg::DEF_PORT_W,
  parameter int unsigned ADDR_W    = ramdisk_pkg::DEF_ADDR_W,
  parameter int unsigned UNIT_BITS = ramdisk_pkg::DEF_UNIT_BITS,
  localparam int unsigned OFF_W    = ADDR_W - UNIT_BITS,
  localparam int unsigned N_UNITS  = 1 << UNIT_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PORT_W-1:0]    cfg_base,
  input  logic [PORT_W-1:0]    io_port,
  input  logic                 io_rd,
  input  logic                 io_wr,
  input  logic [DATA_W-1:0]    io_wdata,
  output logic [DATA_W-1:0]    io_rdata,
  output logic                 io_ready,
  input  logic [N_UNITS-1:0]   unit_present,
  input  logic [N_UNITS-1:0]   unit_wprot,
  output logic                 st_req,
  output logic                 st_we,
  output logic [UNIT_BITS-1:0] st_unit,
  output logic [OFF_W-1:0]     st_off,
  output logic [DATA_W-1:0]    st_wdata,
  input  logic [DATA_W-1:0]    st_rdata
);
  import ramdisk_pkg::*;

  // Named internal events, kept visible for the checker.
  cyc_kind_e         cyc_kind;
  logic              ev_data_rd;
  logic              ev_data_wr;
  logic              ev_addr_load;
  logic              ev_step;
  logic              ev_rd_absent;
  logic              ev_wr_dropped;
  logic [ADDR_W-1:0] addr_q;

  rdk_port_decode #(.PORT_W(PORT_W)) u_decode (
    .cfg_base (cfg_base),
    .io_port  (io_port),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .accept   (io_ready),
    .cyc_kind (cyc_kind)
  );

  assign ev_data_rd   = (cyc_kind == CYC_DATA_RD);
  assign ev_data_wr   = (cyc_kind == CYC_DATA_WR);
  assign ev_addr_load = (cyc_kind == CYC_ADDR_WR);
  assign ev_step      = ev_data_rd | ev_data_wr;

  rdk_addr_reg #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .UNIT_BITS (UNIT_BITS)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_addr_load),
    .load_byte (io_wdata),
    .step      (ev_step),
    .addr_q    (addr_q),
    .unit      (st_unit),
    .off       (st_off)
  );

  rdk_access_gate #(
    .DATA_W    (DATA_W),
    .UNIT_BITS (UNIT_BITS)
  ) u_gate (
    .unit         (st_unit),
    .unit_present (unit_present),
    .unit_wprot   (unit_wprot),
    .data_rd      (ev_data_rd),
    .data_wr      (ev_data_wr),
    .wdata        (io_wdata),
    .st_req       (st_req),
    .st_we        (st_we),
    .st_wdata     (st_wdata),
    .rd_absent    (ev_rd_absent),
    .wr_dropped   (ev_wr_dropped)
  );

  rdk_read_return #(.DATA_W(DATA_W)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_start  (ev_data_rd),
    .rd_absent (ev_rd_absent),
    .st_rdata  (st_rdata),
    .io_ready  (io_ready),
    .io_rdata  (io_rdata)
  );

endmodule

// File: rtl/ramdisk_port_ctrl_chk.sv
module ramdisk_port_ctrl_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned UNIT_BITS = 3,
  localparam int unsigned N_UNITS  = 1 << UNIT_BITS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    addr_q,
  input logic                 ev_addr_load,
  input logic                 ev_step,
  input logic                 ev_data_rd,
  input logic                 ev_rd_absent,
  input logic                 ev_wr_dropped,
  input logic [DATA_W-1:0]    io_wdata,
  input logic [DATA_W-1:0]    io_rdata,
  input logic                 io_ready,
  input logic                 st_req,
  input logic                 st_we,
  input logic [UNIT_BITS-1:0] st_unit,
  input logic [N_UNITS-1:0]   unit_present,
  input logic [N_UNITS-1:0]   unit_wprot
);

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_load |=> addr_q == {$past(addr_q[ADDR_W-DATA_W-1:0]), $past(io_wdata)}); // R3

  AST_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> addr_q == ADDR_W'($past(addr_q) + 1)); // R9

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_step && !ev_addr_load) |=> $stable(addr_q)); // R2

  AST_NO_REQ_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |-> unit_present[st_unit]); // R6

  AST_NO_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && st_we) |-> !unit_wprot[st_unit]); // R8

  AST_DROP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_dropped |-> !st_req); // R8

  AST_READ_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_rd |=> !io_ready); // R5

  AST_WAIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !io_ready |=> io_ready); // R5

  AST_FLOAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_absent |=> ##1 (io_rdata == '1)); // R6

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !io_ready |-> (!st_req && !ev_step && !ev_addr_load)); // R11

endmodule

bind ramdisk_port_ctrl ramdisk_port_ctrl_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .UNIT_BITS (UNIT_BITS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr_q        (addr_q),
  .ev_addr_load  (ev_addr_load),
  .ev_step       (ev_step),
  .ev_data_rd    (ev_data_rd),
  .ev_rd_absent  (ev_rd_absent),
  .ev_wr_dropped (ev_wr_dropped),
  .io_wdata      (io_wdata),
  .io_rdata      (io_rdata),
  .io_ready      (io_ready),
  .st_req        (st_req),
  .st_we         (st_we),
  .st_unit       (st_unit),
  .unit_present  (unit_present),
  .unit_wprot    (unit_wprot)
);

// File: tb/ramdisk_port_ctrl_bench.sv
`timescale 1ns/1ps
module ramdisk_port_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_base;
  logic [7:0]  io_port;
  logic        io_rd, io_wr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        io_ready;
  logic [7:0]  unit_present, unit_wprot;
  logic        st_req, st_we;
  logic [2:0]  st_unit;
  logic [18:0] st_off;
  logic [7:0]  st_wdata;
  logic [7:0]  st_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  logic [21:0] m_addr;   // bench address model

  always #4 clk = ~clk;  // 125 MHz

  ramdisk_port_ctrl u_ramdisk_port_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .io_port(io_port),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_ready(io_ready), .unit_present(unit_present), .unit_wprot(unit_wprot),
    .st_req(st_req), .st_we(st_we), .st_unit(st_unit), .st_off(st_off),
    .st_wdata(st_wdata), .st_rdata(st_rdata)
  );

  // Storage model: sparse array, unwritten bytes follow a fixed pattern.
  logic [7:0] mem [logic [21:0]];
  function automatic logic [7:0] fill(input logic [21:0] a);
    return a[7:0] ^ 8'h5A ^ {a[21:19], a[12:8]};
  endfunction
  function automatic logic [7:0] peek(input logic [21:0] a);
    return mem.exists(a) ? mem[a] : fill(a);
  endfunction
  always @(posedge clk) begin
    if (st_req) begin
      if (st_we) mem[{st_unit, st_off}] = st_wdata;
      else       st_rdata <= peek({st_unit, st_off});
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_addr(input string req);
    chk(req, "address on st_unit/st_off", {10'd0, st_unit, st_off}, {10'd0, m_addr});
  endtask

  // One strobe cycle, driven at the falling edge; comb outputs sampled 1 ns later.
  task automatic strobe(input logic [7:0] port, input logic rd, input logic [7:0] wd);
    @(negedge clk);
    io_port = port; io_rd = rd; io_wr = ~rd; io_wdata = wd;
    #1;
  endtask
  task automatic release_bus;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic load_addr(input logic [21:0] a);
    for (int i = 2; i >= 0; i--) begin
      strobe(cfg_base + 8'd1, 1'b0, a[i*8 +: 8]);
      m_addr = {m_addr[13:0], a[i*8 +: 8]};
      @(posedge clk);
    end
    release_bus();
    chk_addr("R3");
  endtask

  task automatic data_read(input string req, input logic present);
    logic [7:0] exp;
    exp = present ? peek(m_addr) : 8'hFF;
    strobe(cfg_base, 1'b1, 8'h00);
    chk(req, "st_req on read", st_req, present);
    if (present) chk(req, "st_we on read", st_we, 1'b0);
    @(posedge clk);
    release_bus();
    m_addr = m_addr + 22'd1;
    chk(req, "io_ready during wait", io_ready, 1'b0);
    @(negedge clk);
    chk(req, "io_ready after wait", io_ready, 1'b1);
    chk(req, "io_rdata", io_rdata, exp);
    chk_addr("R9");
  endtask

  task automatic data_write(input string req, input logic [7:0] b, input logic lands);
    strobe(cfg_base, 1'b0, b);
    chk(req, "st_req on write", st_req, lands);
    if (lands) begin
      chk(req, "st_we", st_we, 1'b1);
      chk(req, "st_wdata", st_wdata, b);
    end
    chk(req, "io_ready on write", io_ready, 1'b1);
    @(posedge clk);
    release_bus();
    m_addr = m_addr + 22'd1;
    chk_addr("R9");
  endtask

  // Scenario tasks ------------------------------------------------------
  task automatic t_reset;
    chk("R1", "io_ready", io_ready, 1'b1);
    chk("R1", "io_rdata", io_rdata, 8'hFF);
    chk("R1", "st_req", st_req, 1'b0);
    chk_addr("R1");
  endtask

  task automatic t_shift;
    load_addr(22'h12_3456 & 22'h3F_FFFF);
    chk("R4", "st_unit field", st_unit, m_addr[21:19]);
    chk("R4", "st_off field", st_off, m_addr[18:0]);
    // a fourth byte pushes the top one out of the 22-bit register
    strobe(cfg_base + 8'd1, 1'b0, 8'hA7);
    @(posedge clk); release_bus();
    m_addr = {m_addr[13:0], 8'hA7};
    chk_addr("R3");
  endtask

  task automatic t_read_write;
    load_addr({3'd2, 19'h0_1000});
    data_read("R5", 1'b1);
    data_read("R5", 1'b1);
    load_addr({3'd2, 19'h0_1000});
    data_write("R7", 8'hC3, 1'b1);
    data_write("R7", 8'h3C, 1'b1);
    load_addr({3'd2, 19'h0_1000});
    data_read("R7", 1'b1);
    chk("R7", "read back first byte", io_rdata, 8'hC3);
    data_read("R7", 1'b1);
    chk("R7", "read back second byte", io_rdata, 8'h3C);
  endtask

  task automatic t_absent;
    load_addr({3'd5, 19'h0_0010});
    data_read("R6", 1'b0);
    data_write("R8", 8'h77, 1'b0);
    unit_present[5] = 1'b1;
    load_addr({3'd5, 19'h0_0011});
    data_read("R8", 1'b1);
    chk("R8", "absent write left storage", io_rdata, fill({3'd5, 19'h0_0011}));
    unit_present[5] = 1'b0;
  endtask

  task automatic t_protect;
    unit_wprot[3] = 1'b1;
    load_addr({3'd3, 19'h0_0200});
    data_write("R8", 8'hEE, 1'b0);
    load_addr({3'd3, 19'h0_0200});
    data_read("R8", 1'b1);
    chk("R8", "protected byte unchanged", io_rdata, fill({3'd3, 19'h0_0200}));
    unit_wprot[3] = 1'b0;
  endtask

  task automatic t_wrap;
    load_addr({3'd0, 19'h7_FFFF});
    data_write("R9", 8'h11, 1'b1);
    chk("R9", "carry into unit 1", st_unit, 3'd1);
    load_addr(22'h3F_FFFF);
    data_read("R9", 1'b1);
    chk("R9", "wrap to zero", {st_unit, st_off}, 22'd0);
  endtask

  task automatic t_other_ports;
    logic [21:0] keep;
    keep = m_addr;
    strobe(cfg_base + 8'd2, 1'b0, 8'h99);
    chk("R2", "st_req for foreign port", st_req, 1'b0);
    @(posedge clk); release_bus();
    strobe(cfg_base - 8'd1, 1'b1, 8'h00);
    chk("R2", "st_req for foreign read", st_req, 1'b0);
    @(posedge clk); release_bus();
    chk("R2", "io_ready after foreign read", io_ready, 1'b1);
    chk("R2", "address after foreign strobes", {st_unit, st_off}, keep);
    strobe(cfg_base + 8'd1, 1'b1, 8'h00);
    chk("R10", "st_req on address-port read", st_req, 1'b0);
    @(posedge clk); release_bus();
    chk("R10", "io_ready after address-port read", io_ready, 1'b1);
    chk("R10", "address after address-port read", {st_unit, st_off}, keep);
  endtask

  task automatic t_busy;
    load_addr({3'd1, 19'h0_0040});
    strobe(cfg_base, 1'b1, 8'h00);
    @(posedge clk);
    m_addr = m_addr + 22'd1;
    // still strobing, now an address write, during the wait cycle
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b1; io_port = cfg_base + 8'd1; io_wdata = 8'h55;
    #1;
    chk("R11", "io_ready low while busy", io_ready, 1'b0);
    chk("R11", "st_req while busy", st_req, 1'b0);
    @(posedge clk);
    release_bus();
    chk("R11", "address ignores busy strobe", {st_unit, st_off}, m_addr);
    chk("R11", "read data after busy", io_rdata, peek({3'd1, 19'h0_0040}));
  endtask

  task automatic t_base_wrap;
    cfg_base = 8'hFF;   // address port wraps to 0x00
    m_addr = {m_addr[13:0], 8'h21};
    strobe(8'h00, 1'b0, 8'h21);
    @(posedge clk); release_bus();
    chk_addr("R2");
    cfg_base = 8'hC6;
  endtask

  initial begin
    rst_n = 1'b0; cfg_base = 8'hC6; io_port = 8'h00; io_rd = 1'b0; io_wr = 1'b0;
    io_wdata = 8'h00; unit_present = 8'b1100_1111; unit_wprot = 8'h00;
    st_rdata = 8'h00; m_addr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shift();
    t_read_write();
    t_absent();
    t_protect();
    t_wrap();
    t_other_ports();
    t_busy();
    t_base_wrap();
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule